// File: doc/BRIEF.md
# PCIe MSI Capture and Vector Controller

This block watches a stream of inbound memory writes, each carrying a 32-bit address, a 32-bit data word and a valid strobe. It checks whether each write falls inside a programmable message-signalled-interrupt window. The window is given by a 4 KiB-aligned base and a size counted in 4 KiB pages. A write that lands inside the window uses its data word directly as a vector number. If that vector is enabled, its bit is set in a 256-bit pending array. That array is organised as eight 32-bit groups: vector n sits in bit (n mod 32) of group (n div 32).

Software talks to the block through a simple word-addressed register port that is always ready. Writes take effect on the clock edge and reads return combinationally. Through this port, software programs the window, enables vectors per group, reads the pending groups and clears pending bits by writing ones. A single level interrupt summarises the array. It is high while the global MSI mask bit is set and at least one enabled vector is pending, and it drops once every enabled pending bit has been cleared.

Register word addresses (`reg_addr`): 0 = window base (bits 31:12 stored, bits 11:0 read as zero), 1 = window size in 4 KiB pages (bits 19:0), 2 = interrupt mask (bit 0 is the MSI bit), 8..15 = enable group 0..7, 16..23 = pending group 0..7 (write-one-to-clear).

Top module: `msi_vec_ctrl`

## Requirements
- R1: After reset every register reads zero, every vector is disabled, no bit is pending, and `irq_out` is low.
- R2: A valid write whose address lies in [base, base + size*4096) and whose data n is below 256 sets bit (n mod 32) of pending group (n div 32) when that vector is enabled. The bit reads back on the clock edge after the write.
- R3: A write whose address lies below the base or at or above base + size*4096 changes no pending bit. A size of zero matches no address.
- R4: A write inside the window whose data is 256 or larger changes no pending bit.
- R5: A write for a vector whose enable bit is clear changes no pending bit.
- R6: Writing a pending group clears each bit written as 1 and leaves bits written as 0 unchanged. At most one pending bit becomes set per clock.
- R7: When an arriving vector and a software clear target the same bit in the same clock, the bit stays set; other bits cleared in that write still clear.
- R8: `irq_out` is a registered level. It is high one clock after (mask bit 0 is set AND some enabled vector is pending) becomes true, and low one clock after that condition becomes false.
- R9: The base register keeps only address bits 31:12 (bits 11:0 read as zero). The size register counts 4 KiB pages, so size 1 spans exactly 4096 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mw_valid | input | 1 | Inbound memory write strobe |
| mw_addr | input | 32 | Inbound write address (32-bit decode only) |
| mw_data | input | 32 | Inbound write payload, used as vector number |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Summary interrupt level |

## Verification
The hardest case to reach from the ports is an arrival and a clear striking the same pending bit on the same clock edge. Only a set-wins rule keeps that message from being lost. The bench reaches it by driving one inbound write and one pending-group write on the same falling edge. The clear mask covers both the arriving bit and a neighbouring pending bit, so the same edge shows both the survivor and a working clear. The window edges are probed at the first and last word of the window and at the words just outside it.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int unsigned NUM_VEC    = 256;
  localparam int unsigned GRP_W      = 32;
  localparam int unsigned NGRP       = NUM_VEC / GRP_W;
  localparam int unsigned IDX_W      = $clog2(NUM_VEC);
  localparam int unsigned BIT_W      = $clog2(GRP_W);
  localparam int unsigned GSEL_W     = IDX_W - BIT_W;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned PAGE_W     = ADDR_W - PAGE_SHIFT;
  localparam int unsigned SIZE_W     = 20;
  localparam int unsigned RA_W       = 5;

  localparam logic [RA_W-1:0] RA_BASE = 5'd0;
  localparam logic [RA_W-1:0] RA_SIZE = 5'd1;
  localparam logic [RA_W-1:0] RA_MASK = 5'd2;
  localparam int unsigned     EN_OFF  = NGRP;
  localparam int unsigned     PND_OFF = 2 * NGRP;

  localparam int unsigned MASK_MSI_BIT = 0;
endpackage

// File: rtl/msi_win_dec.sv
module msi_win_dec
  import msi_pkg::*;
(
  input  logic              mw_valid,
  input  logic [ADDR_W-1:0] mw_addr,
  input  logic [31:0]       mw_data,
  input  logic [PAGE_W-1:0] base_page,
  input  logic [SIZE_W-1:0] size_pages,
  output logic              win_hit,
  output logic              set_vld,
  output logic [IDX_W-1:0]  set_idx
);
  logic [PAGE_W-1:0] addr_page;
  logic [PAGE_W-1:0] page_off;
  logic              above_base;
  logic              below_end;
  logic              idx_ok;

  always_comb begin
    addr_page  = mw_addr[ADDR_W-1:PAGE_SHIFT];
    above_base = (addr_page >= base_page);
    page_off   = addr_page - base_page;
    below_end  = ({{(SIZE_W > PAGE_W ? SIZE_W - PAGE_W : 0){1'b0}}, page_off} < size_pages);
    win_hit    = mw_valid && above_base && below_end;
    idx_ok     = (mw_data[31:IDX_W] == '0);
    set_vld    = win_hit && idx_ok;
    set_idx    = mw_data[IDX_W-1:0];
  end
endmodule

// File: rtl/msi_pend_bank.sv
module msi_pend_bank
  import msi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_vld,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic [NUM_VEC-1:0] en_flat,
  input  logic [NUM_VEC-1:0] clr_flat,
  output logic [NUM_VEC-1:0] pend_flat,
  output logic               any_active
);
  logic [NGRP-1:0] grp_active;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GRP_W-1:0] set_bits;
    logic [GRP_W-1:0] clr_bits;
    logic [GRP_W-1:0] en_bits;
    logic [GRP_W-1:0] pend_q;
    logic [GRP_W-1:0] pend_d;
    logic             upd;

    always_comb begin
      en_bits  = en_flat[g*GRP_W +: GRP_W];
      clr_bits = clr_flat[g*GRP_W +: GRP_W];
      set_bits = '0;
      if (set_vld && (set_idx[IDX_W-1:BIT_W] == GSEL_W'(g))) begin
        set_bits[set_idx[BIT_W-1:0]] = 1'b1;
      end
      set_bits = set_bits & en_bits;
      upd      = (|set_bits) || (|clr_bits);
      // arrival has priority over a clear of the same bit
      pend_d   = (pend_q & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= '0;
      end else if (upd) begin
        pend_q <= pend_d;
      end
    end

    assign pend_flat[g*GRP_W +: GRP_W] = pend_q;
    assign grp_active[g]               = |(pend_q & en_bits);
  end

  assign any_active = |grp_active;
endmodule

// File: rtl/msi_regs.sv
module msi_regs
  import msi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wen,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic [NUM_VEC-1:0] pend_flat,
  output logic [31:0]        reg_rdata,
  output logic [PAGE_W-1:0]  base_page,
  output logic [SIZE_W-1:0]  size_pages,
  output logic               msi_mask,
  output logic [NUM_VEC-1:0] en_flat,
  output logic [NUM_VEC-1:0] clr_flat
);
  logic [PAGE_W-1:0] base_q, base_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic              mask_q, mask_d;
  logic              base_we, size_we, mask_we;

  always_comb begin
    base_we = reg_wen && (reg_addr == RA_BASE);
    size_we = reg_wen && (reg_addr == RA_SIZE);
    mask_we = reg_wen && (reg_addr == RA_MASK);
    base_d  = reg_wdata[ADDR_W-1:PAGE_SHIFT];
    size_d  = reg_wdata[SIZE_W-1:0];
    mask_d  = reg_wdata[MASK_MSI_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      mask_q <= 1'b0;
    end else begin
      if (base_we) base_q <= base_d;
      if (size_we) size_q <= size_d;
      if (mask_we) mask_q <= mask_d;
    end
  end

  logic [NGRP-1:0][31:0] en_rd;
  logic [NGRP-1:0][31:0] pnd_rd;
  logic [NGRP-1:0]       en_sel;
  logic [NGRP-1:0]       pnd_sel;

  for (genvar g = 0; g < NGRP; g++) begin : g_en
    logic [GRP_W-1:0] en_q;
    logic             en_we;

    always_comb begin
      en_sel[g]  = (reg_addr == RA_W'(EN_OFF + g));
      pnd_sel[g] = (reg_addr == RA_W'(PND_OFF + g));
      en_we      = reg_wen && en_sel[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= '0;
      end else if (en_we) begin
        en_q <= reg_wdata[GRP_W-1:0];
      end
    end

    assign en_flat[g*GRP_W +: GRP_W]  = en_q;
    assign clr_flat[g*GRP_W +: GRP_W] = (reg_wen && pnd_sel[g]) ? reg_wdata[GRP_W-1:0] : '0;
    assign en_rd[g]  = 32'(en_q);
    assign pnd_rd[g] = 32'(pend_flat[g*GRP_W +: GRP_W]);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RA_BASE) reg_rdata = {base_q, {PAGE_SHIFT{1'b0}}};
    if (reg_addr == RA_SIZE) reg_rdata = 32'(size_q);
    if (reg_addr == RA_MASK) reg_rdata = 32'(mask_q);
    for (int g = 0; g < NGRP; g++) begin
      if (en_sel[g])  reg_rdata = en_rd[g];
      if (pnd_sel[g]) reg_rdata = pnd_rd[g];
    end
  end

  assign base_page  = base_q;
  assign size_pages = size_q;
  assign msi_mask   = mask_q;
endmodule

// File: rtl/msi_vec_ctrl.sv
module msi_vec_ctrl
  import msi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mw_valid,
  input  logic [ADDR_W-1:0] mw_addr,
  input  logic [31:0]       mw_data,
  input  logic              reg_wen,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [PAGE_W-1:0]  base_page;
  logic [SIZE_W-1:0]  size_pages;
  logic               msi_mask;
  logic [NUM_VEC-1:0] en_flat;
  logic [NUM_VEC-1:0] clr_flat;
  logic [NUM_VEC-1:0] pend_flat;
  logic               win_hit;
  logic               set_vld;
  logic [IDX_W-1:0]   set_idx;
  logic               any_active;

  msi_win_dec u_dec (
    .mw_valid   (mw_valid),
    .mw_addr    (mw_addr),
    .mw_data    (mw_data),
    .base_page  (base_page),
    .size_pages (size_pages),
    .win_hit    (win_hit),
    .set_vld    (set_vld),
    .set_idx    (set_idx)
  );

  msi_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .reg_wen    (reg_wen),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .pend_flat  (pend_flat),
    .reg_rdata  (reg_rdata),
    .base_page  (base_page),
    .size_pages (size_pages),
    .msi_mask   (msi_mask),
    .en_flat    (en_flat),
    .clr_flat   (clr_flat)
  );

  msi_pend_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .set_vld    (set_vld),
    .set_idx    (set_idx),
    .en_flat    (en_flat),
    .clr_flat   (clr_flat),
    .pend_flat  (pend_flat),
    .any_active (any_active)
  );

  logic irq_q, irq_d;

  always_comb irq_d = msi_mask && any_active;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/msi_vec_ctrl_chk.sv
module msi_vec_ctrl_chk
  import msi_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               mw_valid,
  input logic [31:0]        mw_data,
  input logic               reg_wen,
  input logic               win_hit,
  input logic               msi_mask,
  input logic [NUM_VEC-1:0] en_flat,
  input logic [NUM_VEC-1:0] clr_flat,
  input logic [NUM_VEC-1:0] pend_flat,
  input logic               irq_out
);
  // R8: the interrupt never rises unless the mask bit was set
  a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(msi_mask));

  // R3: a miss with no register traffic leaves the array untouched
  a_r3_miss_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_hit && !reg_wen) |=> $stable(pend_flat));

  // R4: an oversize payload with no register traffic leaves the array untouched
  a_r4_big_data_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && (mw_data[31:IDX_W] != '0) && !reg_wen) |=> $stable(pend_flat));

  // R5: only enabled vectors can become pending
  a_r5_only_enabled_rise: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_flat & ~$past(pend_flat) & ~$past(en_flat)) == '0));

  // R6: at most one bit rises per clock
  a_r6_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(pend_flat & ~$past(pend_flat)) <= 1));

  // R6: a clear without an arrival leaves those bits low
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    !mw_valid |=> ((pend_flat & $past(clr_flat)) == '0));
endmodule

bind msi_vec_ctrl msi_vec_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .mw_valid  (mw_valid),
  .mw_data   (mw_data),
  .reg_wen   (reg_wen),
  .win_hit   (win_hit),
  .msi_mask  (msi_mask),
  .en_flat   (en_flat),
  .clr_flat  (clr_flat),
  .pend_flat (pend_flat),
  .irq_out   (irq_out)
);

// File: tb/tb_msi_vec_ctrl.sv
`timescale 1ns/1ps
module tb_msi_vec_ctrl;
  logic        clk;
  logic        rst_n;
  logic        mw_valid;
  logic [31:0] mw_addr;
  logic [31:0] mw_data;
  logic        reg_wen;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int tests_run = 0;
  int tests_failed = 0;

  localparam logic [31:0] WBASE = 32'h1000_0000;

  msi_vec_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mw_valid(mw_valid), .mw_addr(mw_addr),
    .mw_data(mw_data), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic msi(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    mw_valid = 1'b1; mw_addr = a; mw_data = d;
    @(negedge clk);
    mw_valid = 1'b0;
  endtask

  task automatic clear_all();
    for (int g = 0; g < 8; g++) wr(5'(16 + g), 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 24; a++) begin
      rd(5'(a), v);
      check("R1 reg reset", v, 32'h0);
    end
    check("R1 irq reset", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_setup();
    logic [31:0] v;
    wr(5'd0, WBASE | 32'hABC);
    rd(5'd0, v);
    check("R9 base low bits", v, WBASE);
    wr(5'd1, 32'd2);
    for (int g = 0; g < 7; g++) wr(5'(8 + g), 32'hFFFF_FFFF);
    wr(5'd15, 32'h7FFF_FFFF);   // vector 255 disabled for R5
  endtask

  task automatic t_hit();
    logic [31:0] v;
    msi(WBASE, 32'd37);
    rd(5'd17, v);
    check("R2 vec37 group1 bit5", v, 32'h0000_0020);
    msi(WBASE + 32'h1FFC, 32'd0);
    rd(5'd16, v);
    check("R2 vec0 at window top", v, 32'h0000_0001);
    msi(WBASE + 32'h1000, 32'd223);
    rd(5'd22, v);
    check("R2 vec223 group6 bit31", v, 32'h8000_0000);
    clear_all();
  endtask

  task automatic t_miss();
    logic [31:0] v;
    msi(WBASE - 32'd4, 32'd1);
    msi(WBASE + 32'h2000, 32'd2);
    rd(5'd16, v);
    check("R3 outside window", v, 32'h0);
    wr(5'd1, 32'd1);            // one page: top at WBASE+0x1000
    msi(WBASE + 32'h1000, 32'd3);
    rd(5'd16, v);
    check("R9 size 1 spans 4 KiB", v, 32'h0);
    msi(WBASE + 32'hFFC, 32'd3);
    rd(5'd16, v);
    check("R9 size 1 last word hits", v, 32'h0000_0008);
    wr(5'd1, 32'd0);
    msi(WBASE, 32'd4);
    rd(5'd16, v);
    check("R3 size zero", v, 32'h0000_0008);
    wr(5'd1, 32'd2);
    clear_all();
  endtask

  task automatic t_bigdata_disabled();
    logic [31:0] v;
    msi(WBASE, 32'd256);
    msi(WBASE, 32'h0001_0005);
    for (int g = 0; g < 8; g++) begin
      rd(5'(16 + g), v);
      check("R4 oversize payload", v, 32'h0);
    end
    msi(WBASE, 32'd255);
    rd(5'd23, v);
    check("R5 disabled vec255", v, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    msi(WBASE, 32'd8);
    msi(WBASE, 32'd9);
    msi(WBASE, 32'd10);
    wr(5'd16, 32'h0000_0200);
    rd(5'd16, v);
    check("R6 w1c selective", v, 32'h0000_0500);
    clear_all();
  endtask

  task automatic t_collide();
    logic [31:0] v;
    msi(WBASE, 32'd6);
    @(negedge clk);
    mw_valid = 1'b1; mw_addr = WBASE; mw_data = 32'd5;
    reg_wen = 1'b1; reg_addr = 5'd16; reg_wdata = 32'h0000_0060;
    @(negedge clk);
    mw_valid = 1'b0; reg_wen = 1'b0;
    rd(5'd16, v);
    check("R7 set wins collision", v, 32'h0000_0020);
    clear_all();
  endtask

  task automatic t_irq();
    logic [31:0] v;
    msi(WBASE, 32'd40);
    @(negedge clk); @(negedge clk);
    check("R8 masked stays low", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = 5'd2; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wen = 1'b0;
    check("R8 one clock after mask", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R8 high after mask", {31'b0, irq_out}, 32'h1);
    repeat (5) @(negedge clk);
    check("R8 level holds", {31'b0, irq_out}, 32'h1);
    wr(5'd9, 32'h0);            // disable group 1: vec40 pending but not enabled
    @(negedge clk);
    check("R8 disabled pending drops irq", {31'b0, irq_out}, 32'h0);
    rd(5'd17, v);
    check("R8 raw pending kept", v, 32'h0000_0100);
    wr(5'd9, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R8 re-enable raises irq", {31'b0, irq_out}, 32'h1);
    wr(5'd17, 32'h0000_0100);
    @(negedge clk);
    check("R8 low after clear", {31'b0, irq_out}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; mw_valid = 1'b0; mw_addr = '0; mw_data = '0;
    reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_setup();
    t_hit();
    t_miss();
    t_bigdata_disabled();
    t_w1c();
    t_collide();
    t_irq();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule